// File: doc/BRIEF.md
# Shared Descriptor Ring Sequencer

This block owns a table of 128 buffer descriptors that a 10/100 Ethernet controller shares between its transmit and receive paths. Each entry has two 32-bit words: a flags-and-length word, followed by a buffer pointer word. A programmable split count divides the table. Entries below the count form the transmit ring. Entries from the count upward form the receive ring. The sequencer keeps one current index per ring and tells the transmit datapath when the descriptor at its index may launch. It tells the receive datapath whether a free receive descriptor is available.

When a datapath reports completion, the sequencer writes status back into the flags word and moves that ring's index on. Each ring follows its own wrap rule. If the finished descriptor asked for an interrupt, the sequencer latches a source bit. A single interrupt line is high whenever a latched source is also enabled in the mask register. The host reaches four control registers and the descriptor table through simple write strobes. The table can also be read back combinationally.

Top module: `bd_ring_seq`

## Requirements
- R1: After reset, the split count is 0x40, the transmit index is 0, the receive index is 0x40, and irq, tx_start and rx_ready are all low.
- R2: tx_start is asserted only when all of these hold: transmit is enabled (mode bit 1), the split count is non-zero, the flags word at the transmit index has bit 15 (ready) set, and its length field (bits 31:16) is greater than 4.
- R3: After a transmit completion, the transmit index returns to 0 if the finished flags word has bit 13 (wrap) set. Otherwise it increments, and returns to 0 when the incremented value reaches the split count.
- R4: A transmit completion clears bits 15, 8, 7:4, 3, 2, 1 and 0 of the finished flags word. All other bits are kept.
- R5: rx_ready is high only when receive is enabled (mode bit 0), the split count is below 0x80, and the flags word at the receive index has bit 15 (empty) set. A rx_done strobe while rx_ready is low has no effect.
- R6: After a receive completion, bit 15 of the finished flags word is cleared. The receive index reloads to the split count if that word has bit 13 set or the index is 0x7f. Otherwise it increments.
- R7: A completion whose flags word has bit 14 set latches source bit 0 for transmit or source bit 2 for receive.
- R8: Writing the source register clears each source bit written as 1. irq is high exactly when the source AND the mask is non-zero.
- R9: A 0-to-1 change of mode bit 0 loads the receive index with the split count. A 0-to-1 change of mode bit 1 sets the transmit index to 0 and evaluates the launch condition again.
- R10: A write to the table causes a launch check in the following cycle. Only one launch is outstanding until tx_done arrives.
- R11: Register select codes are 0 for mode, 1 for interrupt source, 2 for interrupt mask and 3 for split count (low 8 bits). Table address is {entry[6:0], word}, where word 0 is the flags word and word 1 is the pointer word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Control register write strobe |
| reg_sel | input | 2 | Control register select |
| reg_wdata | input | 32 | Control register write data |
| desc_we | input | 1 | Descriptor table write strobe |
| desc_addr | input | 8 | Descriptor table word address |
| desc_wdata | input | 32 | Descriptor table write data |
| desc_rdata | output | 32 | Descriptor table read data (combinational) |
| tx_done | input | 1 | Transmit datapath finished the launched descriptor |
| rx_done | input | 1 | Receive datapath filled the current descriptor |
| tx_start | output | 1 | Launch the descriptor at tx_index |
| tx_index | output | 7 | Current transmit descriptor index |
| rx_ready | output | 1 | A free receive descriptor is available |
| rx_index | output | 7 | Current receive descriptor index |
| irq | output | 1 | Masked interrupt request |

## Verification
The hardest cases to reach are the receive reload from the top entry, 0x7f, and the transmit wrap caused by the split count. Both need the ring boundary moved away from its reset value before the index can reach it. The stimulus moves the split count to 0x7e and toggles receive enable so the index starts at 0x7e. Two completions then walk it to 0x7f and back. A split count of 2 forces the transmit index to wrap after two launches. A scoreboard holds the expected launch indexes. Any launch that is not expected, including a second launch while one is outstanding, is reported.

// File: rtl/bd_ring_seq.sv
module bd_ring_seq #(
  parameter int ENTRIES   = 128,
  parameter int SPLIT_RST = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_we,
  input  logic [1:0]                   reg_sel,
  input  logic [31:0]                  reg_wdata,
  input  logic                         desc_we,
  input  logic [$clog2(ENTRIES):0]     desc_addr,
  input  logic [31:0]                  desc_wdata,
  output logic [31:0]                  desc_rdata,
  input  logic                         tx_done,
  input  logic                         rx_done,
  output logic                         tx_start,
  output logic [$clog2(ENTRIES)-1:0]   tx_index,
  output logic                         rx_ready,
  output logic [$clog2(ENTRIES)-1:0]   rx_index,
  output logic                         irq
);
  localparam int IW = $clog2(ENTRIES);
  localparam int CW = IW + 1;
  localparam logic [1:0] SEL_MODE = 2'd0;
  localparam logic [1:0] SEL_SRC  = 2'd1;
  localparam logic [1:0] SEL_MASK = 2'd2;
  localparam logic [1:0] SEL_CNT  = 2'd3;
  localparam logic [31:0] TX_CLR = 32'h0000_81FF;
  localparam logic [31:0] RX_CLR = 32'h0000_8000;

  logic [31:0]   flg [ENTRIES];
  logic [31:0]   ptr [ENTRIES];
  logic [1:0]    mode;
  logic [2:0]    src, msk;
  logic [CW-1:0] cnt;
  logic [IW-1:0] tx_idx, rx_idx;
  logic          chk, busy;

  wire [31:0] tx_w = flg[tx_idx];
  wire [31:0] rx_w = flg[rx_idx];
  wire unused_wdata = ^reg_wdata[31:8];

  wire mode_wr  = reg_we && reg_sel == SEL_MODE;
  wire tx_rise  = mode_wr && reg_wdata[1] && !mode[1];
  wire rx_rise  = mode_wr && reg_wdata[0] && !mode[0];
  wire tx_fire  = tx_done && busy;
  wire rx_fire  = rx_done && rx_ready;

  assign tx_start = chk && !busy && mode[1] && cnt != '0 && tx_w[15] && tx_w[31:16] > 16'd4;
  assign rx_ready = mode[0] && cnt < CW'(ENTRIES) && rx_w[15];
  assign irq      = |(src & msk);
  assign tx_index = tx_idx;
  assign rx_index = rx_idx;
  assign desc_rdata = desc_addr[0] ? ptr[desc_addr[IW:1]] : flg[desc_addr[IW:1]];

  wire [CW-1:0] tx_inc = CW'(tx_idx) + CW'(1);
  wire [IW-1:0] tx_after = (tx_w[13] || tx_inc >= cnt) ? '0 : tx_inc[IW-1:0];
  wire [IW-1:0] rx_after = (rx_w[13] || rx_idx == IW'(ENTRIES - 1)) ? cnt[IW-1:0] : rx_idx + IW'(1);

  wire [2:0] src_clr = (reg_we && reg_sel == SEL_SRC) ? reg_wdata[2:0] : 3'b000;
  wire [2:0] src_set = {rx_fire && rx_w[14], 1'b0, tx_fire && tx_w[14]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) begin
        flg[i] <= '0;
        ptr[i] <= '0;
      end
      mode   <= '0;
      src    <= '0;
      msk    <= '0;
      cnt    <= CW'(SPLIT_RST);
      tx_idx <= '0;
      rx_idx <= IW'(SPLIT_RST);
      chk    <= 1'b0;
      busy   <= 1'b0;
    end else begin
      if (!busy) chk <= 1'b0;
      if (desc_we || tx_rise) chk <= 1'b1;
      if (tx_start) busy <= 1'b1;
      else if (tx_fire) busy <= 1'b0;

      if (desc_we) begin
        if (desc_addr[0]) ptr[desc_addr[IW:1]] <= desc_wdata;
        else              flg[desc_addr[IW:1]] <= desc_wdata;
      end
      if (tx_fire) begin
        flg[tx_idx] <= tx_w & ~TX_CLR;
        tx_idx      <= tx_after;
      end
      if (rx_fire) begin
        flg[rx_idx] <= rx_w & ~RX_CLR;
        rx_idx      <= rx_after;
      end

      src <= (src & ~src_clr) | src_set;
      if (reg_we && reg_sel == SEL_MASK) msk <= reg_wdata[2:0];
      if (reg_we && reg_sel == SEL_CNT)  cnt <= reg_wdata[CW-1:0];
      if (mode_wr) mode <= reg_wdata[1:0];
      if (tx_rise) tx_idx <= '0;
      if (rx_rise) rx_idx <= cnt[IW-1:0];
    end
  end

  // R10
  launch_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);

  // R2
  launch_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> CW'(tx_idx) < cnt);

  // R3
  tx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_fire && !mode_wr) |=> (tx_idx == '0 || tx_idx == $past(tx_idx) + IW'(1)));

  // R6
  rx_empty_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fire && !desc_we) |=> !flg[$past(rx_idx)][15]);

  // R8
  src_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_sel == SEL_SRC && !tx_fire && !rx_fire) |=> (src & $past(reg_wdata[2:0])) == 3'b000);

  // R9
  rx_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rise |=> rx_idx == $past(cnt[IW-1:0]));
endmodule

// File: tb/bd_ring_seq_bench.sv
module bd_ring_seq_bench;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic        desc_we = 1'b0;
  logic [7:0]  desc_addr = '0;
  logic [31:0] desc_wdata = '0;
  logic [31:0] desc_rdata;
  logic        tx_done = 1'b0;
  logic        rx_done = 1'b0;
  logic        tx_start;
  logic [6:0]  tx_index;
  logic        rx_ready;
  logic [6:0]  rx_index;
  logic        irq;

  int errors = 0;
  int checks = 0;
  int exp_q[$];
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  bd_ring_seq u_bd_ring_seq (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .desc_we(desc_we), .desc_addr(desc_addr), .desc_wdata(desc_wdata), .desc_rdata(desc_rdata),
    .tx_done(tx_done), .rx_done(rx_done), .tx_start(tx_start), .tx_index(tx_index),
    .rx_ready(rx_ready), .rx_index(rx_index), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, req, act, exp);
  endtask

  always @(negedge clk) begin
    if (rst_n && tx_start) begin
      if (exp_q.size() == 0) check(1'b0, "R10 unexpected launch", 32'(tx_index), 32'hFFFF_FFFF);
      else begin
        int e;
        e = exp_q.pop_front();
        eq("R2 launch index", 32'(tx_index), 32'(e));
      end
    end
  end

  task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic wr_desc(input int ent, input bit w, input logic [31:0] d);
    @(negedge clk); desc_we = 1'b1; desc_addr = {ent[6:0], w}; desc_wdata = d;
    @(negedge clk); desc_we = 1'b0;
  endtask

  task automatic rd_desc(input int ent, input bit w, output logic [31:0] d);
    @(negedge clk); desc_addr = {ent[6:0], w}; #1; d = desc_rdata;
  endtask

  task automatic pulse_tx();
    @(negedge clk); tx_done = 1'b1;
    @(negedge clk); tx_done = 1'b0;
  endtask

  task automatic pulse_rx();
    @(negedge clk); rx_done = 1'b1;
    @(negedge clk); rx_done = 1'b0;
  endtask

  task automatic launch(input int ent, input logic [31:0] w0);
    exp_q.push_back(ent);
    wr_desc(ent, 1'b0, w0);
    @(negedge clk);
    pulse_tx();
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!finished) begin
      check(1'b0, "watchdog", 32'd0, 32'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    eq("R1 tx index", 32'(tx_index), 32'h0);
    eq("R1 rx index", 32'(rx_index), 32'h40);
    eq("R1 irq", 32'(irq), 32'h0);
    eq("R1 rx_ready", 32'(rx_ready), 32'h0);
    eq("R1 tx_start", 32'(tx_start), 32'h0);

    wr_desc(0, 1'b0, 32'h0040_D9FF);
    eq("R2 disabled no launch", 32'(tx_start), 32'h0);
    exp_q.push_back(0);
    wr_reg(2'd0, 32'h2);
    eq("R9 tx index after enable", 32'(tx_index), 32'h0);
    wr_desc(3, 1'b1, 32'hCAFE_0010);
    @(negedge clk);
    pulse_tx();
    rd_desc(0, 1'b0, rd);
    eq("R4 tx status cleared", rd, 32'h0040_5800);
    eq("R3 tx index increments", 32'(tx_index), 32'h1);
    rd_desc(3, 1'b1, rd);
    eq("R11 pointer word readback", rd, 32'hCAFE_0010);

    eq("R8 masked source no irq", 32'(irq), 32'h0);
    wr_reg(2'd2, 32'h1);
    eq("R7 tx source raises irq", 32'(irq), 32'h1);
    wr_reg(2'd1, 32'h0);
    eq("R8 zero write keeps source", 32'(irq), 32'h1);
    wr_reg(2'd1, 32'h1);
    eq("R8 one write clears source", 32'(irq), 32'h0);

    wr_desc(1, 1'b0, 32'h0004_8000);
    eq("R2 length 4 no launch", 32'(tx_start), 32'h0);
    launch(1, 32'h0005_8000);
    eq("R3 tx index after entry 1", 32'(tx_index), 32'h2);
    eq("R7 no irq bit no source", 32'(irq), 32'h0);

    wr_reg(2'd0, 32'h0);
    wr_reg(2'd0, 32'h2);
    eq("R9 tx rise resets index", 32'(tx_index), 32'h0);

    wr_reg(2'd3, 32'h2);
    launch(0, 32'h0010_8000);
    eq("R3 step below count", 32'(tx_index), 32'h1);
    launch(1, 32'h0010_8000);
    eq("R3 wrap at count", 32'(tx_index), 32'h0);

    wr_reg(2'd3, 32'h40);
    launch(0, 32'h0010_8000);
    eq("R3 step", 32'(tx_index), 32'h1);
    launch(1, 32'h0010_A000);
    eq("R3 wrap bit", 32'(tx_index), 32'h0);

    wr_reg(2'd3, 32'h0);
    wr_desc(0, 1'b0, 32'h0010_8000);
    eq("R2 zero count no launch", 32'(tx_start), 32'h0);
    wr_reg(2'd0, 32'h0);
    wr_reg(2'd3, 32'h40);

    wr_desc(8'h40, 1'b0, 32'h0000_C000);
    eq("R5 rx disabled", 32'(rx_ready), 32'h0);
    wr_reg(2'd0, 32'h1);
    eq("R9 rx reload on enable", 32'(rx_index), 32'h40);
    eq("R5 rx ready", 32'(rx_ready), 32'h1);
    wr_reg(2'd2, 32'h4);
    pulse_rx();
    eq("R6 rx increments", 32'(rx_index), 32'h41);
    rd_desc(8'h40, 1'b0, rd);
    eq("R6 empty cleared", rd, 32'h0000_4000);
    eq("R7 rx source raises irq", 32'(irq), 32'h1);
    wr_reg(2'd1, 32'h4);
    eq("R8 rx source cleared", 32'(irq), 32'h0);

    wr_desc(8'h41, 1'b0, 32'h0000_A000);
    pulse_rx();
    eq("R6 rx wrap bit reload", 32'(rx_index), 32'h40);
    eq("R5 not empty not ready", 32'(rx_ready), 32'h0);
    pulse_rx();
    eq("R5 done ignored when not ready", 32'(rx_index), 32'h40);

    wr_reg(2'd3, 32'h7E);
    wr_reg(2'd0, 32'h0);
    wr_reg(2'd0, 32'h1);
    eq("R9 rx reload to new count", 32'(rx_index), 32'h7E);
    wr_desc(8'h7E, 1'b0, 32'h0000_8000);
    wr_desc(8'h7F, 1'b0, 32'h0000_8000);
    pulse_rx();
    eq("R6 step to last entry", 32'(rx_index), 32'h7F);
    pulse_rx();
    eq("R6 last entry reloads", 32'(rx_index), 32'h7E);

    wr_desc(8'h7E, 1'b0, 32'h0000_8000);
    wr_reg(2'd3, 32'h80);
    eq("R5 full transmit split", 32'(rx_ready), 32'h0);

    repeat (3) @(negedge clk);
    eq("R10 no pending launches", 32'(exp_q.size()), 32'h0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule